// File: doc/BRIEF.md
# Precise Exception Valid-Tracking Controller

This block keeps the bookkeeping that gives a five-stage in-order pipeline precise exceptions. It follows the instructions held in the decode, execute, memory and writeback stages. For each one it keeps a valid bit, a two-bit pending cause, and the payload needed at retirement: program counter, destination register, write and store flags, and the add result. A fault found early is not acted on where it is detected. The fault can be an illegal encoding at decode, signed overflow of a trapping add in execute, or a data access miss in the memory stage. The cause is stored with the instruction and travels with it down the pipe.

When a faulting instruction reaches writeback, the block does four things in the same cycle. It suppresses that instruction's register write and blocks any store from the instruction behind it. It clears the valid bit of every younger instruction, including the one arriving from fetch. It steers fetch to a hardware-fixed handler address. On the following edge it records the faulting program counter and the cause code, so the instruction can be re-executed later. Every older instruction has already retired normally. Ordinary adds wrap modulo 2^32. Branch redirects and stalls from the decode stage pass through the same unit, and an exception takes priority over both.

Top module: `pexc_unit`

## Requirements
- R1: After reset all four stage valid bits are 0, `rfWe`, `dmemWe` and `excTaken` are 0, and `epc` and `ecause` are 0.
- R2: A non-trapping add wraps modulo 2^32 (3000000000+3000000000 gives 1705032704). Its result appears on `rfWdata`, with `rfWaddr` equal to its destination, in the cycle it sits in writeback, which is the fourth clock edge after it is accepted.
- R3: A trapping add whose signed sum overflows raises cause 2 and writes no register. Without overflow it behaves exactly like an ordinary add.
- R4: An exception is taken only while the faulting instruction is in writeback. `excTaken` stays 0 while the instruction is in decode, execute or memory, and a faulting instruction never asserts `dmemWe`.
- R5: In the cycle `excTaken` is 1, `rfWe` and `dmemWe` are 0. On the next edge all four stage valid bits clear, and no squashed instruction writes the register file or data memory afterwards.
- R6: Instructions older than the faulting one retire normally, with their register writes intact.
- R7: In the exception cycle `fetchRedirect` is 1 and `fetchTarget` equals the HANDLER parameter. On the next edge `epc` holds the faulting instruction's PC and `ecause` holds its cause code, encoded as 1 = illegal, 2 = overflow, 3 = data miss.
- R8: An invalid slot never writes and never raises an exception. `inIllegal` with `inValid` low, or `memMiss` with the memory stage empty, has no effect.
- R9: An exception overrides a branch redirect or a stall requested in the same cycle: `fetchTarget` is HANDLER and `fetchHold` is 0.
- R10: `branchReq` without a stall drives `fetchRedirect` with `branchTarget` and discards the instruction presented on the input in that cycle.
- R11: `stallReq` drives `fetchHold`, keeps the decode instruction in place, and inserts an invalid slot into execute. A branch requested during a stall is not acted on.
- R12: The first cause detected is kept. An illegal instruction that also misses reports cause 1, and an overflowing add that also misses reports cause 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Fetch delivers an instruction to decode |
| inPc | input | XLEN | PC of the delivered instruction |
| inRd | input | RAW | Destination register |
| inWe | input | 1 | Instruction writes the register file |
| inMemWr | input | 1 | Instruction writes data memory |
| inTrapAdd | input | 1 | Add traps on signed overflow |
| inIllegal | input | 1 | Decode found an illegal encoding |
| exOpA | input | XLEN | First add operand for the instruction in execute |
| exOpB | input | XLEN | Second add operand for the instruction in execute |
| memMiss | input | 1 | Data access of the memory-stage instruction missed |
| stallReq | input | 1 | Decode interlock request |
| branchReq | input | 1 | Decode branch redirect request |
| branchTarget | input | XLEN | Branch destination |
| fetchRedirect | output | 1 | Fetch must load fetchTarget |
| fetchTarget | output | XLEN | Redirect address |
| fetchHold | output | 1 | Fetch must hold its instruction |
| rfWe | output | 1 | Register file write enable |
| rfWaddr | output | RAW | Register file write address |
| rfWdata | output | XLEN | Register file write data |
| dmemWe | output | 1 | Data memory write enable |
| excTaken | output | 1 | Exception taken this cycle |
| epc | output | XLEN | Recorded faulting PC |
| ecause | output | 2 | Recorded cause code |
| stageValid | output | 4 | Valid bits: bit0 decode, bit1 execute, bit2 memory, bit3 writeback |

## Verification
The add path is swept over every pair from a set of boundary operands: zero, one, both signed extremes, all ones, 3000000000 and two mid values. Each pair is run in wrapping and trapping mode, which separates unsigned carry-out from true signed overflow and shows the wrapped value. Single isolated instructions with each cause, and with pairs of causes, separate the stage where a fault is detected from the stage where it is acted on, and show first-cause priority. A back-to-back stream places a retiring older instruction, the faulting one, a younger store and younger writers in every stage at once, with a branch and a stall requested in the flush cycle. This shows that squashing is precise on both sides and that the exception wins. Separate branch, stall and invalid-slot patterns exercise the redirect, the bubble, and the absence of side effects from empty slots.

// File: rtl/pexc_pkg.sv
package pexc_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_ILLEGAL = 2'd1,
    CAUSE_OVF     = 2'd2,
    CAUSE_MISS    = 2'd3
  } cause_e;

  // strobes from control to datapath
  typedef struct packed {
    logic flush;     // exception taken this cycle
    logic hold;      // front stages keep their contents
    logic capture;   // record faulting PC
    logic useHandler;
  } strobes_t;

  // status from datapath to control
  typedef struct packed {
    logic exOvf;     // trapping add in execute overflows
    logic memStore;  // memory-stage instruction is a store
    logic wbWrite;   // writeback instruction writes a register
  } dpStatus_t;

endpackage

// File: rtl/pexc_ctrl.sv
module pexc_ctrl
  import pexc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inIllegal,
  input  logic       memMiss,
  input  logic       stallReq,
  input  logic       branchReq,
  input  dpStatus_t  status,
  output strobes_t   strobes,
  output logic       fetchRedirect,
  output logic       fetchHold,
  output logic       rfWe,
  output logic       dmemWe,
  output logic       excTaken,
  output logic [1:0] ecause,
  output logic [3:0] stageValid
);

  localparam int unsigned NSTAGE = 4;
  localparam int unsigned S_ID  = 0;
  localparam int unsigned S_EX  = 1;
  localparam int unsigned S_MEM = 2;
  localparam int unsigned S_WB  = 3;

  logic [NSTAGE-1:0] vld;
  cause_e idCause, exCause, memCause, wbCause;
  cause_e nextMemCause, nextWbCause;
  logic   flush, hold, branchAct;

  assign flush     = vld[S_WB] && (wbCause != CAUSE_NONE);
  assign hold      = stallReq && !flush;
  assign branchAct = branchReq && !stallReq && !flush;

  // the oldest recorded cause wins; invalid slots never carry one
  always_comb begin
    if (!vld[S_EX])                nextMemCause = CAUSE_NONE;
    else if (exCause != CAUSE_NONE) nextMemCause = exCause;
    else if (status.exOvf)          nextMemCause = CAUSE_OVF;
    else                            nextMemCause = CAUSE_NONE;

    if (!vld[S_MEM])                nextWbCause = CAUSE_NONE;
    else if (memCause != CAUSE_NONE) nextWbCause = memCause;
    else if (memMiss)                nextWbCause = CAUSE_MISS;
    else                             nextWbCause = CAUSE_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld      <= '0;
      idCause  <= CAUSE_NONE;
      exCause  <= CAUSE_NONE;
      memCause <= CAUSE_NONE;
      wbCause  <= CAUSE_NONE;
    end else if (flush) begin
      vld      <= '0;
      idCause  <= CAUSE_NONE;
      exCause  <= CAUSE_NONE;
      memCause <= CAUSE_NONE;
      wbCause  <= CAUSE_NONE;
    end else begin
      vld[S_WB]  <= vld[S_MEM];
      wbCause    <= nextWbCause;
      vld[S_MEM] <= vld[S_EX];
      memCause   <= nextMemCause;
      if (hold) begin
        vld[S_EX] <= 1'b0;
        exCause   <= CAUSE_NONE;
      end else begin
        vld[S_EX] <= vld[S_ID];
        exCause   <= vld[S_ID] ? idCause : CAUSE_NONE;
        vld[S_ID] <= inValid && !branchAct;
        idCause   <= (inValid && inIllegal && !branchAct) ? CAUSE_ILLEGAL : CAUSE_NONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      ecause <= 2'd0;
    else if (flush) ecause <= wbCause;
  end

  assign strobes.flush      = flush;
  assign strobes.hold       = hold;
  assign strobes.capture    = flush;
  assign strobes.useHandler = flush;

  assign fetchRedirect = flush || branchAct;
  assign fetchHold     = hold;
  assign excTaken      = flush;
  assign rfWe   = vld[S_WB] && (wbCause == CAUSE_NONE) && status.wbWrite;
  assign dmemWe = vld[S_MEM] && (memCause == CAUSE_NONE) && !memMiss
                  && status.memStore && !flush;
  assign stageValid = vld;

endmodule

// File: rtl/pexc_datapath.sv
module pexc_datapath
  import pexc_pkg::*;
#(
  parameter int unsigned     XLEN    = 32,
  parameter int unsigned     RAW     = 5,
  parameter logic [XLEN-1:0] HANDLER = 32'h0000_0180
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobes_t        strobes,
  input  logic [XLEN-1:0] inPc,
  input  logic [RAW-1:0]  inRd,
  input  logic            inWe,
  input  logic            inMemWr,
  input  logic            inTrapAdd,
  input  logic [XLEN-1:0] exOpA,
  input  logic [XLEN-1:0] exOpB,
  input  logic [XLEN-1:0] branchTarget,
  output dpStatus_t       status,
  output logic [XLEN-1:0] fetchTarget,
  output logic [RAW-1:0]  rfWaddr,
  output logic [XLEN-1:0] rfWdata,
  output logic [XLEN-1:0] epc
);

  localparam int unsigned MSB = XLEN - 1;

  // payload of decode and execute
  logic [XLEN-1:0] idPc, exPc, memPc, wbPc;
  logic [RAW-1:0]  idRd, exRd, memRd, wbRd;
  logic            idWe, exWe, memWe, wbWe;
  logic            idSt, exSt, memSt;
  logic            idTrap, exTrap;
  logic [XLEN-1:0] memRes, wbRes;
  logic [XLEN-1:0] sum;

  assign sum = exOpA + exOpB;   // modulo 2^XLEN

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idPc <= '0; idRd <= '0; idWe <= 1'b0; idSt <= 1'b0; idTrap <= 1'b0;
      exPc <= '0; exRd <= '0; exWe <= 1'b0; exSt <= 1'b0; exTrap <= 1'b0;
    end else if (!strobes.hold) begin
      idPc <= inPc; idRd <= inRd; idWe <= inWe; idSt <= inMemWr; idTrap <= inTrapAdd;
      exPc <= idPc; exRd <= idRd; exWe <= idWe; exSt <= idSt; exTrap <= idTrap;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memPc <= '0; memRd <= '0; memWe <= 1'b0; memSt <= 1'b0; memRes <= '0;
      wbPc  <= '0; wbRd  <= '0; wbWe  <= 1'b0; wbRes <= '0;
    end else begin
      memPc <= exPc;  memRd <= exRd;  memWe <= exWe; memSt <= exSt; memRes <= sum;
      wbPc  <= memPc; wbRd  <= memRd; wbWe  <= memWe; wbRes <= memRes;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                epc <= '0;
    else if (strobes.capture) epc <= wbPc;
  end

  assign status.exOvf    = exTrap && (exOpA[MSB] == exOpB[MSB]) && (sum[MSB] != exOpA[MSB]);
  assign status.memStore = memSt;
  assign status.wbWrite  = wbWe;

  assign fetchTarget = strobes.useHandler ? HANDLER : branchTarget;
  assign rfWaddr     = wbRd;
  assign rfWdata     = wbRes;

endmodule

// File: rtl/pexc_unit.sv
module pexc_unit
  import pexc_pkg::*;
#(
  parameter int unsigned     XLEN    = 32,
  parameter int unsigned     RAW     = 5,
  parameter logic [XLEN-1:0] HANDLER = 32'h0000_0180
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [XLEN-1:0] inPc,
  input  logic [RAW-1:0]  inRd,
  input  logic            inWe,
  input  logic            inMemWr,
  input  logic            inTrapAdd,
  input  logic            inIllegal,
  input  logic [XLEN-1:0] exOpA,
  input  logic [XLEN-1:0] exOpB,
  input  logic            memMiss,
  input  logic            stallReq,
  input  logic            branchReq,
  input  logic [XLEN-1:0] branchTarget,
  output logic            fetchRedirect,
  output logic [XLEN-1:0] fetchTarget,
  output logic            fetchHold,
  output logic            rfWe,
  output logic [RAW-1:0]  rfWaddr,
  output logic [XLEN-1:0] rfWdata,
  output logic            dmemWe,
  output logic            excTaken,
  output logic [XLEN-1:0] epc,
  output logic [1:0]      ecause,
  output logic [3:0]      stageValid
);

  strobes_t  strobes;
  dpStatus_t status;

  pexc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inIllegal(inIllegal),
    .memMiss(memMiss), .stallReq(stallReq), .branchReq(branchReq),
    .status(status), .strobes(strobes), .fetchRedirect(fetchRedirect),
    .fetchHold(fetchHold), .rfWe(rfWe), .dmemWe(dmemWe), .excTaken(excTaken),
    .ecause(ecause), .stageValid(stageValid)
  );

  pexc_datapath #(.XLEN(XLEN), .RAW(RAW), .HANDLER(HANDLER)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inPc(inPc), .inRd(inRd),
    .inWe(inWe), .inMemWr(inMemWr), .inTrapAdd(inTrapAdd), .exOpA(exOpA),
    .exOpB(exOpB), .branchTarget(branchTarget), .status(status),
    .fetchTarget(fetchTarget), .rfWaddr(rfWaddr), .rfWdata(rfWdata), .epc(epc)
  );

endmodule

// File: rtl/pexc_checker.sv
module pexc_checker #(
  parameter int unsigned     XLEN    = 32,
  parameter logic [XLEN-1:0] HANDLER = 32'h0000_0180
) (
  input logic            clk,
  input logic            rstN,
  input logic            stallReq,
  input logic            fetchRedirect,
  input logic [XLEN-1:0] fetchTarget,
  input logic            fetchHold,
  input logic            rfWe,
  input logic            dmemWe,
  input logic            excTaken,
  input logic [1:0]      ecause,
  input logic [3:0]      stageValid
);

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |=> (stageValid == 4'b0000)); // R5

  AST_NO_WRITE_ON_EXC: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |-> (!rfWe && !dmemWe)); // R5

  AST_EXC_AT_WB: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |-> stageValid[3]); // R4

  AST_HANDLER_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |-> (fetchRedirect && fetchTarget == HANDLER)); // R7

  AST_CAUSE_RECORDED: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |=> (ecause != 2'd0)); // R7

  AST_EXC_BEATS_STALL: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |-> !fetchHold); // R9

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (stallReq && !excTaken) |-> fetchHold); // R11

  AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rstN)
    (stallReq && !excTaken) |=> !stageValid[1]); // R11

endmodule

bind pexc_unit pexc_checker #(.XLEN(XLEN), .HANDLER(HANDLER)) u_chk (
  .clk(clk), .rstN(rstN), .stallReq(stallReq), .fetchRedirect(fetchRedirect),
  .fetchTarget(fetchTarget), .fetchHold(fetchHold), .rfWe(rfWe),
  .dmemWe(dmemWe), .excTaken(excTaken), .ecause(ecause), .stageValid(stageValid)
);

// File: tb/pexc_unit_tb.sv
module pexc_unit_tb;

  localparam int unsigned     XLEN    = 32;
  localparam int unsigned     RAW     = 5;
  localparam logic [XLEN-1:0] HANDLER = 32'h0000_0180;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            inValid = 0, inWe = 0, inMemWr = 0, inTrapAdd = 0, inIllegal = 0;
  logic [XLEN-1:0] inPc = '0, exOpA = '0, exOpB = '0, branchTarget = '0;
  logic [RAW-1:0]  inRd = '0;
  logic            memMiss = 0, stallReq = 0, branchReq = 0;
  logic            fetchRedirect, fetchHold, rfWe, dmemWe, excTaken;
  logic [XLEN-1:0] fetchTarget, rfWdata, epc;
  logic [RAW-1:0]  rfWaddr;
  logic [1:0]      ecause;
  logic [3:0]      stageValid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  pexc_unit #(.XLEN(XLEN), .RAW(RAW), .HANDLER(HANDLER)) u_dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic signedOvf(input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, s;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    s  = sa + sb;
    return (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  // one isolated instruction through the pipe; cause codes 1 illegal, 2 overflow, 3 miss
  task automatic runOne(input bit trap, input logic [31:0] a, input logic [31:0] b,
                        input bit ill, input bit miss, input bit store,
                        input logic [31:0] pc, input logic [4:0] rd);
    logic [63:0] wide;
    logic [1:0]  expCause;
    wide = {32'd0, a} + {32'd0, b};
    if (ill)                          expCause = 2'd1;
    else if (trap && signedOvf(a, b)) expCause = 2'd2;
    else if (miss)                    expCause = 2'd3;
    else                              expCause = 2'd0;
    @(negedge clk);
    inValid = 1; inPc = pc; inRd = rd; inWe = !store; inMemWr = store;
    inTrapAdd = trap; inIllegal = ill; exOpA = a; exOpB = b;
    @(negedge clk);  // in decode
    inValid = 0; inIllegal = 0;
    chk("R4 no exc in decode", excTaken, 0);
    @(negedge clk);  // in execute
    chk("R4 no exc in execute", excTaken, 0);
    @(negedge clk);  // in memory
    memMiss = miss;
    #1;
    chk("R4 no exc in memory", excTaken, 0);
    chk("R4 store gated by cause", dmemWe, store && expCause == 2'd0);
    @(negedge clk);  // in writeback
    memMiss = 0;
    #1;
    chk("R4 exc in writeback", excTaken, expCause != 2'd0);
    chk("R3 reg write gated", rfWe, !store && expCause == 2'd0);
    if (!store && expCause == 2'd0) begin
      chk("R2 wrapped sum", rfWdata, wide[31:0]);
      chk("R2 dest reg", rfWaddr, rd);
    end
    if (expCause != 2'd0) chk("R7 handler target", fetchTarget, HANDLER);
    @(negedge clk);
    chk("R5 pipe empty", stageValid, 4'b0000);
    if (expCause != 2'd0) begin
      chk("R7 epc", epc, pc);
      chk("R12 cause", ecause, expCause);
    end
  endtask

  initial begin
    logic [31:0] ops [8];
    ops[0] = 32'h0000_0000; ops[1] = 32'h0000_0001; ops[2] = 32'h7FFF_FFFF;
    ops[3] = 32'h8000_0000; ops[4] = 32'hFFFF_FFFF; ops[5] = 32'd3000000000;
    ops[6] = 32'h1234_5678; ops[7] = 32'h4000_0000;

    #1;
    chk("R1 valid after reset", stageValid, 0);
    chk("R1 rfWe after reset", rfWe, 0);
    chk("R1 excTaken after reset", excTaken, 0);
    chk("R1 epc after reset", epc, 0);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 dmemWe idle", dmemWe, 0);
    chk("R1 ecause idle", ecause, 0);

    // R2 explicit wrap example
    runOne(0, 32'd3000000000, 32'd3000000000, 0, 0, 0, 32'h40, 5'd9);
    chk("R2 3e9+3e9", rfWdata, 32'd1705032704);
    // R3 same operands trap
    runOne(1, 32'd3000000000, 32'd3000000000, 0, 0, 0, 32'h44, 5'd9);

    // R2 R3 sweep
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int m = 0; m < 2; m++)
          runOne(m[0], ops[i], ops[j], 0, 0, 0, 32'h1000 + 32'(i*64 + j*8 + m*4), 5'(i + j + 1));

    // R4 R12 cause mixes
    runOne(0, 5, 6, 1, 0, 0, 32'h300, 5'd3);
    runOne(0, 5, 6, 0, 1, 0, 32'h304, 5'd3);
    runOne(0, 5, 6, 1, 1, 0, 32'h308, 5'd3);
    runOne(1, 32'h7FFF_FFFF, 1, 0, 1, 0, 32'h30C, 5'd3);
    runOne(0, 5, 6, 0, 0, 1, 32'h310, 5'd0);
    runOne(0, 5, 6, 0, 1, 1, 32'h314, 5'd0);

    // R5 R6 R9 precise squash with a back-to-back stream
    exOpA = 5; exOpB = 6; inTrapAdd = 0;
    @(negedge clk); inValid = 1; inPc = 32'h100; inRd = 1; inWe = 1; inMemWr = 0; inIllegal = 0;
    @(negedge clk); inPc = 32'h104; inRd = 2; inIllegal = 1;
    @(negedge clk); inPc = 32'h108; inRd = 0; inWe = 0; inMemWr = 1; inIllegal = 0;
    @(negedge clk); inPc = 32'h10C; inRd = 3; inWe = 1; inMemWr = 0;
    @(negedge clk); inPc = 32'h110; inRd = 4;
    #1;
    chk("R6 older retires", rfWe, 1);
    chk("R6 older dest", rfWaddr, 1);
    chk("R6 older data", rfWdata, 11);
    @(negedge clk);
    inPc = 32'h114; inRd = 5; branchReq = 1; stallReq = 1; branchTarget = 32'h900;
    #1;
    chk("R5 all stages full", stageValid, 4'b1111);
    chk("R5 exc taken", excTaken, 1);
    chk("R5 no reg write", rfWe, 0);
    chk("R5 younger store blocked", dmemWe, 0);
    chk("R9 target is handler", fetchTarget, HANDLER);
    chk("R9 redirect", fetchRedirect, 1);
    chk("R9 no hold", fetchHold, 0);
    @(negedge clk);
    inValid = 0; branchReq = 0; stallReq = 0;
    chk("R5 all squashed", stageValid, 4'b0000);
    chk("R7 epc stream", epc, 32'h104);
    chk("R7 cause stream", ecause, 2'd1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R5 no later write", {rfWe, dmemWe, excTaken}, 3'b000);
    end

    // R10 branch squashes incoming
    @(negedge clk);
    inValid = 1; inPc = 32'h500; inRd = 7; inWe = 1; branchReq = 1; branchTarget = 32'h0000_0A00;
    #1;
    chk("R10 redirect", fetchRedirect, 1);
    chk("R10 target", fetchTarget, 32'h0000_0A00);
    chk("R10 no hold", fetchHold, 0);
    @(negedge clk);
    inValid = 0; branchReq = 0;
    chk("R10 incoming dropped", stageValid, 4'b0000);

    // R11 stall holds decode and inserts a bubble
    @(negedge clk); inValid = 1; inPc = 32'h200; inRd = 5; inWe = 1;
    @(negedge clk); stallReq = 1; branchReq = 1; inPc = 32'h204; inRd = 6;
    #1;
    chk("R11 hold", fetchHold, 1);
    chk("R11 branch ignored in stall", fetchRedirect, 0);
    @(negedge clk);
    stallReq = 0; branchReq = 0; inValid = 0;
    chk("R11 decode held, bubble", stageValid, 4'b0001);
    @(negedge clk);
    chk("R11 advance", stageValid, 4'b0010);
    @(negedge clk);
    @(negedge clk);
    chk("R11 held instr retires", {rfWe, rfWaddr}, {1'b1, 5'd5});
    @(negedge clk);
    chk("R11 dropped instr absent", rfWe, 0);

    // R8 invalid slots have no effect
    @(negedge clk); inValid = 0; inIllegal = 1; memMiss = 1; inWe = 1; inMemWr = 1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      #1;
      chk("R8 invalid no exc", excTaken, 0);
      chk("R8 invalid no write", {rfWe, dmemWe}, 2'b00);
    end
    inIllegal = 0; memMiss = 0; inWe = 0; inMemWr = 0;
    @(negedge clk);
    chk("R8 pipe empty", stageValid, 4'b0000);
    chk("R8 cause unchanged", ecause, 2'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule